// File: doc/BRIEF.md
# Serial Peripheral Shift Port with Read-Sequence Flag Clearing

This block is a byte-wide SPI shift engine that sits behind a small register port of a bus-attached controller. Software sees two locations: a status word holding a transfer-complete flag and a write-collision flag, and a data location. Writing the data location queues a byte for the shifter. Reading it returns the last byte received. A static mode input selects master or slave operation. As master, the block drives SCK from the system clock through a fixed divider. As slave, it follows the SCK and select inputs of an external master, after synchronizing them.

Both flags stay set until software completes a two-access sequence: a status read taken while a flag is up, then a data read. A write to the data location never lowers the collision flag. The sequence is cancelled by any other register access in between. A slave that has been given no new byte sends back on MISO the byte it received last. A slave that is not selected releases MISO.

Top module: `spi_flagged_port`

## Requirements
- R1: The transfer-complete flag (status bit 7) is set in the cycle after the eighth SCK falling edge of a byte. In that same update the received byte is copied into the read buffer that data reads return (reg_sel=1).
- R2: A status read (reg_sel=0) taken while a flag is set, followed by a data read (reg_sel=1), clears both the transfer-complete flag and the write-collision flag (status bit 6).
- R3: When a collision is flagged while a byte is still shifting, the same status-then-data read pair clears the write-collision flag before the byte ends.
- R4: A write to the data location never clears the write-collision flag.
- R5: A data write while a byte is shifting sets the write-collision flag. The written value is discarded and the byte in flight is sent unchanged.
- R6: A status read arms the clear only when a flag is set. Any register access other than the arming status read and the following data read cancels the armed state. A data read that is not armed leaves both flags unchanged.
- R7: In master mode (is_master=1), a data write while idle starts a transfer. SCK idles low and has a period of 2*SCK_HALF system clocks.
- R8: Bits travel MSB first in clock mode 0. Output data changes after a falling SCK edge, and input data is sampled on the rising edge.
- R9: In slave mode, MISO output enable is low while ss_n_i is high. Deselecting the slave in the middle of a byte discards the partial byte and does not set the transfer-complete flag.
- R10: A slave whose data location has not been written since its last transfer shifts out the byte it received in that transfer.
- R11: Reset clears both flags, the shift register and the read buffer. It also holds MISO output enable and SCK low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 selects master mode, 0 selects slave mode (static) |
| reg_sel | input | 1 | Register select: 0 status, 1 data |
| reg_wr | input | 1 | Register write strobe (wins over reg_rd) |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for the selected register |
| sck_o | output | 1 | SCK driven in master mode |
| sck_i | input | 1 | SCK received in slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_i | input | 1 | Serial data in for master mode |
| miso_oe | output | 1 | Output enable for MISO, high only while a slave is selected |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The inline properties watch the flag logic on every cycle. They check that a completed byte raises the complete flag and loads the read buffer, and that a collision write raises and keeps the collision flag. They check that an armed data read lowers both flags and an unarmed one does not. They also check that an unselected slave resets its bit count and that master SCK stays low when idle. Only the bench scenarios can show the rest: the serial bit order and SCK period at the pins, the byte in flight surviving a collision, the slave echo of the previous byte, and the recovery of a deselected partial byte. These are measured against a bench-side peer model.

// File: rtl/spi_fp_pkg.sv
package spi_fp_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_DATA   = 1'b1
  } reg_sel_e;

  // clear fires only when a data read lands on an armed sequence
  function automatic logic clear_fires(input logic armed, input logic rd_data);
    return armed && rd_data;
  endfunction

  // arming needs a status read while at least one flag is up
  function automatic logic arm_fires(input logic rd_stat, input logic tc, input logic wcol);
    return rd_stat && (tc || wcol);
  endfunction
endpackage

// File: rtl/spi_fp_sync.sv
module spi_fp_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_fp_engine.sv
module spi_fp_engine #(
  parameter int DW   = 8,
  parameter int HALF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_byte,
  input  logic          sck_s,
  input  logic          ss_s,
  input  logic          sdi_m,
  input  logic          sdi_s,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          sdo,
  output logic          sck_o
);
  localparam int CW   = $clog2(DW + 1);
  localparam int DIVW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DIVW-1:0] DIV_MAX = DIVW'(HALF - 1);
  localparam logic [CW-1:0]   LAST_IX = CW'(DW - 1);

  logic [DW-1:0]   sr;
  logic [CW-1:0]   bcnt;
  logic [DIVW-1:0] div;
  logic            rx_bit, sck_q, sck_prev;

  // named internal events
  logic m_tick, rise_evt, fall_evt, load_ok;

  assign m_tick   = is_master && busy && (div == DIV_MAX);
  assign rise_evt = is_master ? (m_tick && !sck_q) : (!ss_s && sck_s && !sck_prev);
  assign fall_evt = is_master ? (m_tick && sck_q)  : (!ss_s && !sck_s && sck_prev);
  assign done     = fall_evt && (bcnt == LAST_IX);
  assign load_ok  = wr_req && !busy;
  assign rx_byte  = {sr[DW-2:0], rx_bit};
  assign sdo      = sr[DW-1];
  assign sck_o    = is_master && sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      bcnt     <= '0;
      div      <= '0;
      rx_bit   <= 1'b0;
      sck_q    <= 1'b0;
      sck_prev <= 1'b0;
      busy     <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      if (is_master && busy) div <= (div == DIV_MAX) ? '0 : div + DIVW'(1);
      if (load_ok) begin
        sr <= wr_byte;
        if (is_master) begin
          busy  <= 1'b1;
          div   <= '0;
          sck_q <= 1'b0;
          bcnt  <= '0;
        end
      end
      if (rise_evt) begin
        rx_bit <= is_master ? sdi_m : sdi_s;
        if (is_master) sck_q <= 1'b1;
        else           busy  <= 1'b1;
      end
      if (fall_evt) begin
        sr   <= rx_byte;
        bcnt <= done ? '0 : bcnt + CW'(1);
        if (is_master) sck_q <= 1'b0;
        if (done)      busy  <= 1'b0;
      end
      if (!is_master && ss_s) begin
        busy <= 1'b0;
        bcnt <= '0;
      end
    end
  end

  a_r5_inflight_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && busy && !fall_evt) |=> $stable(sr));
  a_r7_idle_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !busy) |-> !sck_o);
  a_r9_deselect_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && ss_s) |=> (bcnt == '0 && !busy));
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt < CW'(DW));
endmodule

// File: rtl/spi_fp_flags.sv
module spi_fp_flags
  import spi_fp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stat,
  input  logic          rd_data,
  input  logic          wr_stat,
  input  logic          wr_data,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  output logic          tc,
  output logic          wcol,
  output logic [DW-1:0] rbuf
);
  logic armed;
  logic any_acc, arm_now, clr_now, coll_now;

  assign any_acc  = rd_stat || rd_data || wr_stat || wr_data;
  assign arm_now  = arm_fires(rd_stat, tc, wcol);
  assign clr_now  = clear_fires(armed, rd_data);
  assign coll_now = wr_data && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc    <= 1'b0;
      wcol  <= 1'b0;
      armed <= 1'b0;
      rbuf  <= '0;
    end else begin
      if (done)         tc <= 1'b1;
      else if (clr_now) tc <= 1'b0;
      if (coll_now)     wcol <= 1'b1;
      else if (clr_now) wcol <= 1'b0;
      if (arm_now)      armed <= 1'b1;
      else if (any_acc) armed <= 1'b0;
      if (done)         rbuf <= rx_byte;
    end
  end

  a_r1_done_sets_tc: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> tc);
  a_r1_rbuf_latched: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (rbuf == $past(rx_byte)));
  a_r5_collision_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> wcol);
  a_r4_write_keeps_wcol: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && wcol) |=> wcol);
  a_r2_armed_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && armed && !done) |=> (!tc && !wcol));
  a_r6_unarmed_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !armed && tc) |=> tc);
endmodule

// File: rtl/spi_flagged_port.sv
module spi_flagged_port
  import spi_fp_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SCK_HALF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sck_o,
  input  logic          sck_i,
  output logic          mosi_o,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          miso_i,
  output logic          miso_oe,
  input  logic          ss_n_i
);
  logic rd_stat, rd_data, wr_stat, wr_data;
  logic sck_s, ss_s, mosi_s;
  logic busy, done, sdo, tc, wcol;
  logic [DW-1:0] rx_byte, rbuf, stat_word;

  // one access per cycle: a write wins over a read
  assign wr_stat = reg_wr && (reg_sel == SEL_STATUS);
  assign wr_data = reg_wr && (reg_sel == SEL_DATA);
  assign rd_stat = reg_rd && !reg_wr && (reg_sel == SEL_STATUS);
  assign rd_data = reg_rd && !reg_wr && (reg_sel == SEL_DATA);

  spi_fp_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_i, ss_n_i, mosi_i}),
    .q({sck_s, ss_s, mosi_s})
  );

  spi_fp_engine #(.DW(DW), .HALF(SCK_HALF)) u_eng (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .wr_req(wr_data), .wr_byte(reg_wdata),
    .sck_s(sck_s), .ss_s(ss_s), .sdi_m(miso_i), .sdi_s(mosi_s),
    .busy(busy), .done(done), .rx_byte(rx_byte), .sdo(sdo), .sck_o(sck_o)
  );

  spi_fp_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .rd_stat(rd_stat), .rd_data(rd_data), .wr_stat(wr_stat), .wr_data(wr_data),
    .busy(busy), .done(done), .rx_byte(rx_byte),
    .tc(tc), .wcol(wcol), .rbuf(rbuf)
  );

  assign stat_word = {tc, wcol, {(DW-2){1'b0}}};
  assign reg_rdata = (reg_sel == SEL_DATA) ? rbuf : stat_word;
  assign mosi_o    = is_master && sdo;
  assign miso_o    = !is_master && sdo;
  assign miso_oe   = !is_master && !ss_s;

  a_r9_unselected_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && $past(ss_n_i) && ss_n_i && $past(ss_n_i, 2)) |=> !miso_oe);
endmodule

// File: tb/sim_spi_flagged_port.sv
`timescale 1ns/1ps
module sim_spi_flagged_port;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n, is_master, reg_sel, reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic sck_o, sck_i, mosi_o, mosi_i, miso_o, miso_i, miso_oe, ss_n_i;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  spi_flagged_port #(.DW(8), .SCK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_o(sck_o), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_i(miso_i), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  // bench-side peer for master mode, clock mode 0
  logic [7:0] peer_tx = 8'h00;
  logic [7:0] peer_rx = 8'h00;
  always @(posedge sck_o) peer_rx <= {peer_rx[6:0], mosi_o};
  always @(negedge sck_o) peer_tx <= {peer_tx[6:0], 1'b0};
  assign miso_i = peer_tx[7];

  function automatic logic [7:0] exp_status(input logic tc, input logic wcol);
    return {tc, wcol, 6'b000000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic sel, input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    reg_wr = wr; reg_rd = !wr; reg_sel = sel; reg_wdata = wd;
    #1 rd = reg_rdata;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; is_master = mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic poll_done(output logic [7:0] st);
    st = 8'h00;
    for (int i = 0; i < 200 && !st[7]; i++) acc(1'b0, 1'b0, 8'h00, st);
  endtask

  task automatic clear_flags();
    logic [7:0] d;
    acc(1'b0, 1'b0, 8'h00, d);
    acc(1'b0, 1'b1, 8'h00, d);
  endtask

  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] stx, output logic [7:0] got);
    logic [7:0] st;
    peer_tx = stx;
    acc(1'b1, 1'b1, tx, st);
    poll_done(st);
    acc(1'b0, 1'b1, 8'h00, got);
  endtask

  // slave-side master model: drives nbits then deselects
  task automatic s_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = 8'h00;
    @(negedge clk);
    ss_n_i = 1'b0; mosi_i = mo[7];
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mi = {mi[6:0], miso_o};
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
      if (i < 7) mosi_i = mo[6-i];
      repeat (8) @(negedge clk);
    end
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, got, st, tx, stx, prev;
    realtime t1, t2;
    reg_sel = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    sck_i = 1'b0; mosi_i = 1'b0; ss_n_i = 1'b1; rst_n = 1'b0; is_master = 1'b1;
    void'($urandom(32'd4417));

    // R11 reset state
    do_reset(1'b1);
    acc(1'b0, 1'b0, 8'h00, d); chk("R11 status after reset", d, exp_status(0, 0));
    acc(1'b0, 1'b1, 8'h00, d); chk("R11 read buffer after reset", d, 8'h00);
    chk("R11 sck low", sck_o, 0);
    chk("R11 miso_oe low", miso_oe, 0);

    // R7 SCK period, R8 order, R1 completion
    peer_tx = 8'h96;
    acc(1'b1, 1'b1, 8'hC3, d);
    @(posedge sck_o); t1 = $realtime;
    @(posedge sck_o); t2 = $realtime;
    chk("R7 sck period ps", int'((t2 - t1) * 1000), 2 * HALF * 5000);
    poll_done(st);
    chk("R1 tc after byte", st, exp_status(1, 0));
    acc(1'b0, 1'b1, 8'h00, got);
    chk("R1 rx byte in buffer", got, 8'h96);
    chk("R8 peer received msb first", peer_rx, 8'hC3);
    acc(1'b0, 1'b0, 8'h00, d); chk("R2 flags cleared", d, exp_status(0, 0));

    // random master traffic
    for (int n = 0; n < 16; n++) begin
      tx = 8'($urandom); stx = 8'($urandom);
      m_xfer(tx, stx, got);
      chk("R8 master rx", got, stx);
      chk("R8 master tx", peer_rx, tx);
      acc(1'b0, 1'b0, 8'h00, d); chk("R2 cleared after pair", d, exp_status(0, 0));
    end

    // R5 / R4 / R3 collision in flight
    peer_tx = 8'h5A;
    acc(1'b1, 1'b1, 8'hA7, d);
    repeat (6) @(negedge clk);
    acc(1'b1, 1'b1, 8'h11, d);
    acc(1'b0, 1'b0, 8'h00, d); chk("R5 wcol set", d, exp_status(0, 1));
    acc(1'b1, 1'b1, 8'h22, d);
    acc(1'b0, 1'b0, 8'h00, d); chk("R4 write keeps wcol", d, exp_status(0, 1));
    acc(1'b0, 1'b1, 8'h00, d);
    acc(1'b0, 1'b0, 8'h00, d); chk("R3 wcol cleared mid byte", d, exp_status(0, 0));
    poll_done(st);
    acc(1'b0, 1'b1, 8'h00, got);
    chk("R5 byte in flight unchanged", peer_rx, 8'hA7);
    chk("R5 rx still correct", got, 8'h5A);

    // R6 cancel by an intervening access
    peer_tx = 8'h3E;
    acc(1'b1, 1'b1, 8'h81, d);
    repeat (90) @(negedge clk);
    acc(1'b0, 1'b0, 8'h00, d); chk("R1 tc set unpolled", d, exp_status(1, 0));
    acc(1'b1, 1'b0, 8'hFF, d);
    acc(1'b0, 1'b1, 8'h00, d);
    acc(1'b0, 1'b0, 8'h00, d); chk("R6 cancelled sequence keeps tc", d, exp_status(1, 0));
    clear_flags();
    acc(1'b0, 1'b0, 8'h00, d); chk("R2 clear after cancel", d, exp_status(0, 0));

    // R6 status read with no flag does not arm
    acc(1'b0, 1'b0, 8'h00, d);
    acc(1'b1, 1'b1, 8'h42, d);
    repeat (90) @(negedge clk);
    acc(1'b0, 1'b1, 8'h00, d);
    acc(1'b0, 1'b0, 8'h00, d); chk("R6 unarmed data read keeps tc", d, exp_status(1, 0));

    // R11 reset mid-run clears flags and buffer
    do_reset(1'b1);
    acc(1'b0, 1'b0, 8'h00, d); chk("R11 flags after reset", d, exp_status(0, 0));
    acc(1'b0, 1'b1, 8'h00, d); chk("R11 buffer after reset", d, 8'h00);

    // slave mode
    do_reset(1'b0);
    chk("R9 miso_oe low unselected", miso_oe, 0);
    acc(1'b1, 1'b1, 8'h3C, d);
    s_bits(8'hA5, 8, got);
    chk("R8 slave sent loaded byte", got, 8'h3C);
    acc(1'b0, 1'b0, 8'h00, d); chk("R1 slave tc", d, exp_status(1, 0));
    acc(1'b0, 1'b1, 8'h00, d); chk("R1 slave rx", d, 8'hA5);
    chk("R9 miso_oe released", miso_oe, 0);
    s_bits(8'h6B, 8, got);
    chk("R10 echo previous byte", got, 8'hA5);
    clear_flags();
    prev = 8'h6B;

    // R9 partial byte discarded
    s_bits(8'hFF, 3, got);
    acc(1'b0, 1'b0, 8'h00, d); chk("R9 partial no tc", d, exp_status(0, 0));
    s_bits(8'h19, 8, got);
    acc(1'b0, 1'b1, 8'h00, d); chk("R9 full byte after abort", d, 8'h19);
    clear_flags();
    prev = 8'h19;

    for (int n = 0; n < 6; n++) begin
      tx = 8'($urandom); stx = 8'($urandom);
      if (n[0]) acc(1'b1, 1'b1, stx, d);
      s_bits(tx, 8, got);
      chk(n[0] ? "R8 slave loaded" : "R10 slave echo", got, n[0] ? stx : prev);
      acc(1'b0, 1'b0, 8'h00, d);
      acc(1'b0, 1'b1, 8'h00, d); chk("R1 slave rx random", d, tx);
      prev = tx;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule